// File: doc/BRIEF.md
# Coalescing Store Buffer with Load Forwarding

This block sits on the path from a write-through first-level data cache to the second-level port. Each accepted store lands in a small queue of block-sized slots, after which the processor treats the store as done. A store whose block address already sits in a slot is folded into that slot byte by byte. A store to a new block takes the next free slot. Slots leave for the second level one at a time, oldest first, as full-block writes carrying a per-byte valid mask.

A load lookup port compares a block address against every occupied slot in the same cycle. If the matching slot holds every byte the load asks for, the word is returned from the buffer and the slot stays in place. If some bytes are missing, the load is told to wait until that slot has drained. A pending read miss from the cache owns the shared second-level port ahead of any drain that has not yet started. A drain already on the port stays there until it is accepted.

Top module: `wbuf_coalesce`

## Requirements
- R1: After reset the buffer is empty: `l2_valid` is 0, a store is not stalled, and every lookup returns `ld_hit`=0 and `ld_wait`=0.
- R2: A store is taken in the cycle `st_valid`=1 and `st_stall`=0. `st_word` selects the 8-byte word within the block, so `st_be` bit b covers block byte `st_word*8+b`. The stored bytes are visible to lookups from the next cycle.
- R3: A store whose block address matches an occupied slot that is not being drained is merged into that slot. Newer bytes replace older ones, and no new slot is used, even when all slots are occupied.
- R4: `st_stall` is 1 when all DEPTH slots are occupied and the store matches none of them, or when the matching slot is the one on the second-level port. A stalled store changes nothing.
- R5: A lookup whose requested bytes are all present in the matching slot gives `ld_hit`=1 and `ld_data` = that 8-byte word. The slot is not removed by the lookup.
- R6: A lookup that matches a slot missing any requested byte gives `ld_wait`=1 and `ld_hit`=0. A lookup that matches no slot gives both 0.
- R7: Slots drain in the order they were first allocated. A drain presents `l2_write`=1, `l2_addr` = block address, `l2_wdata` with block byte k at bits 8k+7:8k, and `l2_wmask` bit k = byte k valid.
- R8: When `rd_req`=1 and no write is already on the port, the port carries the read: `l2_valid`=1, `l2_write`=0, `l2_addr`=`rd_addr`, and `rd_gnt`=`l2_ready`. A write already on the port is not pre-empted.
- R9: A write on the port keeps address, data and mask unchanged until `l2_ready`. Its slot is freed on the accepting edge, so a store stalled for lack of space is taken from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store present |
| st_addr | input | ADDR_W | Store block address |
| st_word | input | WIDX_W | Word index within the block |
| st_data | input | WORD_BYTES*8 | Store word |
| st_be | input | WORD_BYTES | Byte enables of the store word |
| st_stall | output | 1 | Store not taken this cycle (buffer full or target draining) |
| ld_valid | input | 1 | Lookup present |
| ld_addr | input | ADDR_W | Lookup block address |
| ld_word | input | WIDX_W | Lookup word index |
| ld_be | input | WORD_BYTES | Bytes the load needs |
| ld_hit | output | 1 | Load served from the buffer |
| ld_wait | output | 1 | Load must wait for the matching slot to drain |
| ld_data | output | WORD_BYTES*8 | Forwarded word |
| rd_req | input | 1 | Cache read miss waiting for the port |
| rd_addr | input | ADDR_W | Read miss block address |
| rd_gnt | output | 1 | Read accepted by the second level |
| l2_valid | output | 1 | Port request valid |
| l2_write | output | 1 | 1 = drain write, 0 = read |
| l2_addr | output | ADDR_W | Port block address |
| l2_wdata | output | BLK_BYTES*8 | Drained block data |
| l2_wmask | output | BLK_BYTES | Drained byte mask |
| l2_ready | input | 1 | Second level accepts the request |

## Verification
A merge into the wrong slot, or a byte mask that is not updated, shows up in the next lookup of that word as wrong data or as a wait in place of a hit. It shows up again as a wrong `l2_wmask` when that slot reaches the port. A broken head pointer or occupancy count shows up as a drain address out of order, or as a wrong `st_stall` on the first store made against a full buffer. A fault in the port hand-off appears at the ports in the same cycle: a read hidden behind a write that had not started, or a write whose fields change before `l2_ready`.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   typedef enum logic [1:0] {
      PORT_IDLE  = 2'd0,
      PORT_READ  = 2'd1,
      PORT_WRITE = 2'd2
   } port_sel_e;
endpackage

// File: rtl/cwb_match.sv
module cwb_match #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 26
) (
   input  logic [DEPTH-1:0]             vld,
   input  logic [DEPTH-1:0][ADDR_W-1:0] tags,
   input  logic [ADDR_W-1:0]            key,
   output logic [DEPTH-1:0]             hit
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit[g] = vld[g] && (tags[g] == key);
   end
endmodule

// File: rtl/cwb_place.sv
module cwb_place #(
   parameter int BLK_BYTES  = 32,
   parameter int WORD_BYTES = 8,
   parameter int WIDX_W     = 2
) (
   input  logic [WIDX_W-1:0]         word,
   input  logic [WORD_BYTES-1:0]     be,
   input  logic [WORD_BYTES*8-1:0]   data,
   output logic [BLK_BYTES-1:0]      byte_mask,
   output logic [BLK_BYTES*8-1:0]    bit_mask,
   output logic [BLK_BYTES*8-1:0]    blk_data
);
   localparam int BW = BLK_BYTES * 8;

   assign byte_mask = BLK_BYTES'(be) << (int'(word) * WORD_BYTES);
   assign blk_data  = BW'(data) << (int'(word) * WORD_BYTES * 8);

   for (genvar b = 0; b < BLK_BYTES; b++) begin : g_expand
      assign bit_mask[b*8 +: 8] = {8{byte_mask[b]}};
   end
endmodule

// File: rtl/cwb_port_arb.sv
module cwb_port_arb
   import cwb_pkg::*;
#(
   parameter int ADDR_W    = 26,
   parameter int BLK_BYTES = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_req,
   input  logic [ADDR_W-1:0]      rd_addr,
   input  logic                   wr_pend,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [BLK_BYTES*8-1:0] wr_data,
   input  logic [BLK_BYTES-1:0]   wr_mask,
   input  logic                   l2_ready,
   output logic                   l2_valid,
   output logic                   l2_write,
   output logic [ADDR_W-1:0]      l2_addr,
   output logic [BLK_BYTES*8-1:0] l2_wdata,
   output logic [BLK_BYTES-1:0]   l2_wmask,
   output logic                   rd_gnt,
   output logic                   wr_sel,
   output logic                   wr_acc
);
   logic      busy_q;
   port_sel_e sel;

   always_comb begin
      if (busy_q)                 sel = PORT_WRITE;
      else if (rd_req)            sel = PORT_READ;
      else if (wr_pend)           sel = PORT_WRITE;
      else                        sel = PORT_IDLE;
   end

   assign wr_sel   = (sel == PORT_WRITE);
   assign l2_valid = (sel != PORT_IDLE);
   assign l2_write = wr_sel;
   assign l2_addr  = wr_sel ? wr_addr : rd_addr;
   assign l2_wdata = wr_sel ? wr_data : '0;
   assign l2_wmask = wr_sel ? wr_mask : '0;
   assign rd_gnt   = (sel == PORT_READ) && l2_ready;
   assign wr_acc   = wr_sel && l2_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= wr_sel && !l2_ready;
   end

   p_hold_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_valid && l2_write && !l2_ready) |=>
      (l2_valid && l2_write && $stable(l2_addr) && $stable(l2_wdata) && $stable(l2_wmask)));

   p_read_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !busy_q) |-> (l2_valid && !l2_write && (l2_addr == rd_addr)));

   p_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt |-> (rd_req && l2_ready && !l2_write));
endmodule

// File: rtl/wbuf_coalesce.sv
module wbuf_coalesce #(
   parameter int ADDR_W     = 26,
   parameter int DEPTH      = 4,
   parameter int BLK_BYTES  = 32,
   parameter int WORD_BYTES = 8,
   localparam int WORDS     = BLK_BYTES / WORD_BYTES,
   localparam int WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int BW        = BLK_BYTES * 8,
   localparam int WW        = WORD_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [WIDX_W-1:0] st_word,
   input  logic [WW-1:0]     st_data,
   input  logic [WORD_BYTES-1:0] st_be,
   output logic              st_stall,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [WIDX_W-1:0] ld_word,
   input  logic [WORD_BYTES-1:0] ld_be,
   output logic              ld_hit,
   output logic              ld_wait,
   output logic [WW-1:0]     ld_data,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_gnt,
   output logic              l2_valid,
   output logic              l2_write,
   output logic [ADDR_W-1:0] l2_addr,
   output logic [BW-1:0]     l2_wdata,
   output logic [BLK_BYTES-1:0] l2_wmask,
   input  logic              l2_ready
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   initial begin : g_param_chk
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 2");
      assert (WORD_BYTES >= 1 && BLK_BYTES % WORD_BYTES == 0 && WORDS >= 2)
         else $error("block must hold a whole number of words, at least two");
   end

   logic [DEPTH-1:0]                vld_q;
   logic [DEPTH-1:0][ADDR_W-1:0]    tag_q;
   logic [DEPTH-1:0][BW-1:0]        dat_q;
   logic [DEPTH-1:0][BLK_BYTES-1:0] msk_q;
   logic [PTR_W-1:0]                hd_q, tl_q;
   logic [CNT_W-1:0]                cnt_q;

   // store side
   logic [DEPTH-1:0]     st_hit_vec;
   logic [BLK_BYTES-1:0] st_bmask;
   logic [BW-1:0]        st_bits, st_blk;
   logic                 st_merge, st_block, st_acc, alloc;
   logic                 wr_sel, wr_acc;

   cwb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_st_match (
      .vld(vld_q), .tags(tag_q), .key(st_addr), .hit(st_hit_vec));

   cwb_place #(.BLK_BYTES(BLK_BYTES), .WORD_BYTES(WORD_BYTES), .WIDX_W(WIDX_W)) u_st_place (
      .word(st_word), .be(st_be), .data(st_data),
      .byte_mask(st_bmask), .bit_mask(st_bits), .blk_data(st_blk));

   assign st_merge = |st_hit_vec;
   assign st_block = (st_merge && st_hit_vec[hd_q] && wr_sel) ||
                     (!st_merge && (cnt_q == CNT_W'(DEPTH)));
   assign st_stall = st_valid && st_block;
   assign st_acc   = st_valid && !st_block;
   assign alloc    = st_acc && !st_merge;

   // occupancy and ordering
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         hd_q  <= '0;
         tl_q  <= '0;
         cnt_q <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (wr_acc && hd_q == PTR_W'(e)) vld_q[e] <= 1'b0;
            if (alloc  && tl_q == PTR_W'(e)) vld_q[e] <= 1'b1;
         end
         if (wr_acc) hd_q <= hd_q + 1'b1;
         if (alloc)  tl_q <= tl_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(wr_acc);
      end
   end

   // slot contents
   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk) begin
         if (alloc && tl_q == PTR_W'(e)) begin
            tag_q[e] <= st_addr;
            dat_q[e] <= st_blk;
            msk_q[e] <= st_bmask;
         end else if (st_acc && st_hit_vec[e]) begin
            dat_q[e] <= (dat_q[e] & ~st_bits) | (st_blk & st_bits);
            msk_q[e] <= msk_q[e] | st_bmask;
         end
      end
   end

   // load side
   logic [DEPTH-1:0]     ld_hit_vec;
   logic [BW-1:0]        sel_dat;
   logic [BLK_BYTES-1:0] sel_msk, ld_bmask;
   logic                 ld_match, ld_cover;

   cwb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ld_match (
      .vld(vld_q), .tags(tag_q), .key(ld_addr), .hit(ld_hit_vec));

   always_comb begin
      sel_dat = '0;
      sel_msk = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (ld_hit_vec[e]) begin
            sel_dat = sel_dat | dat_q[e];
            sel_msk = sel_msk | msk_q[e];
         end
      end
   end

   assign ld_bmask = BLK_BYTES'(ld_be) << (int'(ld_word) * WORD_BYTES);
   assign ld_match = ld_valid && (|ld_hit_vec);
   assign ld_cover = ((sel_msk & ld_bmask) == ld_bmask);
   assign ld_hit   = ld_match && ld_cover;
   assign ld_wait  = ld_match && !ld_cover;
   assign ld_data  = ld_hit ? WW'(sel_dat >> (int'(ld_word) * WW)) : '0;

   // second-level port
   cwb_port_arb #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .wr_pend(cnt_q != '0),
      .wr_addr(tag_q[hd_q]), .wr_data(dat_q[hd_q]), .wr_mask(msk_q[hd_q]),
      .l2_ready(l2_ready),
      .l2_valid(l2_valid), .l2_write(l2_write), .l2_addr(l2_addr),
      .l2_wdata(l2_wdata), .l2_wmask(l2_wmask),
      .rd_gnt(rd_gnt), .wr_sel(wr_sel), .wr_acc(wr_acc));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   p_count_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld_q) == int'(cnt_q));

   p_unique_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_hit_vec));

   p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_merge && cnt_q == CNT_W'(DEPTH)) |-> st_stall);

   p_fwd_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_hit && ld_wait));

   p_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && !alloc) |=> ($past(cnt_q) - cnt_q == CNT_W'(1)));
endmodule

// File: tb/test_wbuf_coalesce.sv
`timescale 1ns/1ps
module test_wbuf_coalesce;
   localparam int AW = 26;
   localparam int BB = 32;
   localparam int BW = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          st_valid = 0, ld_valid = 0, rd_req = 0, l2_ready = 0;
   logic [AW-1:0] st_addr = '0, ld_addr = '0, rd_addr = '0;
   logic [1:0]    st_word = '0, ld_word = '0;
   logic [63:0]   st_data = '0;
   logic [7:0]    st_be = '0, ld_be = '0;
   logic          st_stall, ld_hit, ld_wait, rd_gnt, l2_valid, l2_write;
   logic [63:0]   ld_data;
   logic [AW-1:0] l2_addr;
   logic [BW-1:0] l2_wdata;
   logic [BB-1:0] l2_wmask;

   wbuf_coalesce i_wbuf_coalesce (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_word(st_word), .st_data(st_data),
      .st_be(st_be), .st_stall(st_stall),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_word(ld_word), .ld_be(ld_be),
      .ld_hit(ld_hit), .ld_wait(ld_wait), .ld_data(ld_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
      .l2_valid(l2_valid), .l2_write(l2_write), .l2_addr(l2_addr),
      .l2_wdata(l2_wdata), .l2_wmask(l2_wmask), .l2_ready(l2_ready));

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   localparam logic [AW-1:0] A1 = 26'h100, A2 = 26'h101, A3 = 26'h102,
                             A4 = 26'h103, A5 = 26'h104, RA = 26'h3000;

   task automatic chk(input string req, input string what,
                      input logic [BW-1:0] act, input logic [BW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put_store(input logic [AW-1:0] a, input logic [1:0] w,
                            input logic [63:0] d, input logic [7:0] be,
                            input logic exp_stall, input string req);
      @(negedge clk);
      st_valid = 1; st_addr = a; st_word = w; st_data = d; st_be = be;
      #1;
      chk(req, "st_stall", BW'(st_stall), BW'(exp_stall));
      @(posedge clk);
      #1 st_valid = 0;
   endtask

   task automatic look(input logic [AW-1:0] a, input logic [1:0] w, input logic [7:0] be,
                       input logic exp_hit, input logic exp_wait,
                       input logic [63:0] exp_data, input string req);
      @(negedge clk);
      ld_valid = 1; ld_addr = a; ld_word = w; ld_be = be;
      #1;
      chk(req, "ld_hit", BW'(ld_hit), BW'(exp_hit));
      chk(req, "ld_wait", BW'(ld_wait), BW'(exp_wait));
      if (exp_hit) chk(req, "ld_data", BW'(ld_data), BW'(exp_data));
      ld_valid = 0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      st_valid = 1; st_addr = A5; st_be = 8'hFF; ld_valid = 1; ld_addr = A5; ld_be = 8'hFF;
      #1;
      chk("R1", "l2_valid", BW'(l2_valid), '0);
      chk("R1", "st_stall", BW'(st_stall), '0);
      chk("R1", "ld_hit", BW'(ld_hit), '0);
      chk("R1", "ld_wait", BW'(ld_wait), '0);
      st_valid = 0; ld_valid = 0;
   endtask

   task automatic t_forward();
      @(negedge clk); rd_req = 1; rd_addr = RA; l2_ready = 0;
      put_store(A1, 2'd1, 64'h1111_2222_3333_4444, 8'hFF, 1'b0, "R2");
      look(A1, 2'd1, 8'hFF, 1, 0, 64'h1111_2222_3333_4444, "R2");
      look(A1, 2'd1, 8'h0F, 1, 0, 64'h1111_2222_3333_4444, "R5");
      look(A1, 2'd0, 8'h01, 0, 1, '0, "R6 partial");
      look(26'h1FF, 2'd1, 8'hFF, 0, 0, '0, "R6 no match");
   endtask

   task automatic t_merge_full();
      put_store(A1, 2'd1, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F, 1'b0, "R3");
      look(A1, 2'd1, 8'hFF, 1, 0, 64'h1111_2222_CCCC_DDDD, "R3 merged");
      put_store(A1, 2'd3, 64'h0000_0000_0000_00EE, 8'h01, 1'b0, "R3");
      put_store(A2, 2'd0, 64'h0202_0202_0202_0202, 8'hFF, 1'b0, "R2");
      put_store(A3, 2'd2, 64'h0303_0303_0303_0303, 8'hFF, 1'b0, "R2");
      put_store(A4, 2'd0, 64'h0404_0404_0404_0404, 8'hFF, 1'b0, "R2");
      put_store(A1, 2'd0, 64'h7700_0000_0000_0000, 8'h80, 1'b0, "R3 merge when full");
      put_store(A5, 2'd1, 64'h0505_0505_0505_0505, 8'hFF, 1'b1, "R4 full");
      look(A5, 2'd1, 8'hFF, 0, 0, '0, "R4 stalled store dropped");
   endtask

   task automatic t_read_and_drain();
      logic [BW-1:0] exp_blk;
      logic [AW-1:0] order [4];
      exp_blk = '0;
      exp_blk[64 +: 64]  = 64'h1111_2222_CCCC_DDDD;
      exp_blk[56 +: 8]   = 8'h77;
      exp_blk[192 +: 8]  = 8'hEE;
      @(negedge clk); #1;
      chk("R8", "l2_valid", BW'(l2_valid), BW'(1));
      chk("R8", "l2_write", BW'(l2_write), '0);
      chk("R8", "l2_addr", BW'(l2_addr), BW'(RA));
      chk("R8", "rd_gnt low", BW'(rd_gnt), '0);
      @(negedge clk); l2_ready = 1; #1;
      chk("R8", "rd_gnt", BW'(rd_gnt), BW'(1));
      @(negedge clk); l2_ready = 0; rd_req = 0; #1;
      chk("R7", "l2_write", BW'(l2_write), BW'(1));
      chk("R7", "l2_addr oldest", BW'(l2_addr), BW'(A1));
      chk("R7", "l2_wmask", BW'(l2_wmask), BW'(32'h0100_FF80));
      chk("R7", "l2_wdata", l2_wdata, exp_blk);
      @(negedge clk); rd_req = 1; #1;
      chk("R8", "write not pre-empted", BW'(l2_write), BW'(1));
      chk("R9", "l2_addr held", BW'(l2_addr), BW'(A1));
      chk("R9", "l2_wdata held", l2_wdata, exp_blk);
      put_store(A1, 2'd2, 64'h1, 8'h01, 1'b1, "R4 target draining");
      @(negedge clk); l2_ready = 1;
      @(negedge clk); l2_ready = 0; #1;
      chk("R8", "read after drain", BW'(l2_write), '0);
      put_store(A5, 2'd1, 64'h0505_0505_0505_0505, 8'hFF, 1'b0, "R9 slot freed");
      look(A1, 2'd1, 8'hFF, 0, 0, '0, "R9 drained slot gone");
      @(negedge clk); rd_req = 0; #1;
      chk("R7", "second drain mask", BW'(l2_wmask), BW'(32'h0000_00FF));
      order[0] = A2; order[1] = A3; order[2] = A4; order[3] = A5;
      for (int i = 0; i < 4; i++) begin
         if (i > 0) begin @(negedge clk); #1; end
         chk("R7", "drain order", BW'(l2_addr), BW'(order[i]));
         chk("R7", "drain write", BW'(l2_write), BW'(1));
         l2_ready = 1;
      end
      @(negedge clk); #1;
      chk("R7", "empty after drain", BW'(l2_valid), '0);
      l2_ready = 0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      t_reset();
      t_forward();
      t_merge_full();
      t_read_and_drain();
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end
endmodule